// File: doc/BRIEF.md
# Network Address Flit Stripper

This block sits on the receive side between a network-on-chip port and an IP core. Each transfer from the network opens with a flit that carries the network address. The second flit may carry the original memory-mapped address, and payload flits follow. A static two-bit mode input picks how the leading address is treated:

- **Pass-through:** every flit is forwarded as it arrives.
- **Strip:** the network address flit is removed and the rest of the transfer is forwarded.
- **Replace:** the network address flit is removed and the second flit goes out marked as the address, so the original address takes the place of the network address.

On both sides a flit is a data word with a data-valid marker and an address-valid marker. The address-valid marker on an input flit marks the start of a new transfer. The downstream side returns a stall signal. The block holds its output in one register stage and passes the stall upstream, so that no flit is lost or repeated. The mode must only change while no transfer is in flight.

Top module: `noc_addr_stripper`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `dn_dv` and `dn_av` are 0 and `up_stall` is 0.
- R2: With mode 2'b00 (pass-through) or 2'b11 (treated as pass-through), every accepted flit appears on the output with its data and address-valid marker unchanged.
- R3: With mode 2'b01 (strip), an accepted flit with `up_av`=1 is consumed and produces no cycle with `dn_dv`=1.
- R4: With mode 2'b01, every accepted flit with `up_av`=0 is forwarded with unchanged data and `dn_av`=0.
- R5: With mode 2'b10 (replace), the first accepted flit with `up_av`=0 after an address flit is emitted with unchanged data and `dn_av`=1.
- R6: With mode 2'b10, address flits are consumed without output, and flits after the second flit of a transfer are emitted with `dn_av`=0.
- R7: Any accepted flit with `up_av`=1 restarts position tracking, even in the middle of a transfer. Flits with `up_av`=0 that arrive before any address flit count as payload.
- R8: While `dn_dv`=1 and `dn_stall`=1, `up_stall` is 1 and the output data, markers and valid are held until the stall drops.
- R9: A flit is accepted when `up_dv`=1 and `up_stall`=0. A forwarded flit appears on the output in the cycle after the clock edge that accepts it.
- R10: Under any stall pattern, the sequence of output flits equals the sequence the mode implies for the accepted input flits, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 pass, 01 strip, 10 replace, 11 pass |
| up_data | input | DATA_W | Incoming flit data from the network |
| up_dv | input | 1 | Incoming flit valid |
| up_av | input | 1 | Incoming flit is a network address (transfer start) |
| up_stall | output | 1 | Stall toward the network; flit not accepted while high |
| dn_data | output | DATA_W | Outgoing flit data to the IP |
| dn_dv | output | 1 | Outgoing flit valid |
| dn_av | output | 1 | Outgoing flit is an address |
| dn_stall | input | 1 | Stall from the IP |

## Verification
A wrong position state shows up at the ports on the very next forwarded flit. In replace mode it appears as an address marker on a payload flit, or as a data marker on the flit that should carry the original address. In strip mode it appears as a missing or extra output cycle. A wrong stall or register decision shows up as a repeated or missing flit in the output order, one cycle after the faulty edge. For that reason the bench compares every completed output handshake against an ordered expectation built from the accepted inputs. It also checks that nothing remains owed after each stream drains.

// File: rtl/nas_pkg.sv
package nas_pkg;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'b00,
    MODE_STRIP   = 2'b01,
    MODE_REPLACE = 2'b10,
    MODE_RSVD    = 2'b11
  } nas_mode_e;

  // Position of a flit inside its transfer
  typedef enum logic [1:0] {
    POS_HEAD   = 2'b00,
    POS_SECOND = 2'b01,
    POS_BODY   = 2'b10
  } nas_pos_e;

  typedef struct packed {
    logic keep;   // flit produces an output cycle
    logic av;     // output address-valid marker
  } nas_act_t;

  // Position of the current flit, given its marker and the tracked state
  function automatic nas_pos_e flit_pos(input logic av, input nas_pos_e trk);
    if (av)                    return POS_HEAD;
    else if (trk == POS_SECOND) return POS_SECOND;
    else                       return POS_BODY;
  endfunction

  // Tracked state after a flit in position p has been accepted
  function automatic nas_pos_e next_trk(input nas_pos_e p);
    return (p == POS_HEAD) ? POS_SECOND : POS_BODY;
  endfunction

  // What happens to a flit in position p under mode m
  function automatic nas_act_t flit_action(input logic [1:0] m, input nas_pos_e p);
    nas_act_t a;
    a.keep = 1'b1;
    a.av   = 1'b0;
    case (m)
      MODE_STRIP: begin
        a.keep = (p != POS_HEAD);
        a.av   = 1'b0;
      end
      MODE_REPLACE: begin
        a.keep = (p != POS_HEAD);
        a.av   = (p == POS_SECOND);
      end
      default: begin
        a.keep = 1'b1;
        a.av   = (p == POS_HEAD);
      end
    endcase
    return a;
  endfunction

endpackage

// File: rtl/nas_pos_tracker.sv
module nas_pos_tracker
  import nas_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  logic     av,
  output nas_pos_e cur_pos,
  output logic     at_second
);

  nas_pos_e trk_q;

  assign cur_pos   = flit_pos(av, trk_q);
  assign at_second = (trk_q == POS_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n)    trk_q <= POS_BODY;
    else if (take) trk_q <= next_trk(cur_pos);
  end

endmodule

// File: rtl/nas_action_dec.sv
module nas_action_dec
  import nas_pkg::*;
(
  input  logic [1:0] mode,
  input  nas_pos_e   pos,
  input  logic       take,
  output logic       load,
  output logic       load_av,
  output logic       drop
);

  nas_act_t act;

  always_comb begin
    act     = flit_action(mode, pos);
    load    = take & act.keep;
    load_av = act.av;
    drop    = take & ~act.keep;
  end

endmodule

// File: rtl/nas_out_stage.sv
module nas_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_av,
  input  logic [DATA_W-1:0] load_data,
  input  logic              dn_stall,
  output logic              ready,
  output logic              vld,
  output logic              av,
  output logic [DATA_W-1:0] data
);

  logic              vld_q;
  logic              av_q;
  logic [DATA_W-1:0] data_q;

  assign ready = ~vld_q | ~dn_stall;
  assign vld   = vld_q;
  assign av    = av_q;
  assign data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      av_q   <= 1'b0;
      data_q <= '0;
    end else if (ready) begin
      vld_q <= load;
      av_q  <= load & load_av;
      if (load) data_q <= load_data;
    end
  end

endmodule

// File: rtl/noc_addr_stripper.sv
module noc_addr_stripper
  import nas_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_dv,
  input  logic              up_av,
  output logic              up_stall,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_dv,
  output logic              dn_av,
  input  logic              dn_stall
);

  logic     ready;
  logic     take;
  logic     load;
  logic     load_av;
  logic     drop;
  logic     at_second;
  nas_pos_e cur_pos;

  assign take     = up_dv & ready;
  assign up_stall = ~ready;

  nas_pos_tracker u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .av        (up_av),
    .cur_pos   (cur_pos),
    .at_second (at_second)
  );

  nas_action_dec u_dec (
    .mode    (mode),
    .pos     (cur_pos),
    .take    (take),
    .load    (load),
    .load_av (load_av),
    .drop    (drop)
  );

  nas_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_av   (load_av),
    .load_data (up_data),
    .dn_stall  (dn_stall),
    .ready     (ready),
    .vld       (dn_dv),
    .av        (dn_av),
    .data      (dn_data)
  );

endmodule

// File: rtl/noc_addr_stripper_chk.sv
module noc_addr_stripper_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] up_data,
  input logic              up_dv,
  input logic              up_av,
  input logic              up_stall,
  input logic [DATA_W-1:0] dn_data,
  input logic              dn_dv,
  input logic              dn_av,
  input logic              dn_stall,
  input logic              at_second
);

  logic acc;
  assign acc = up_dv & ~up_stall;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!dn_dv && !dn_av));

  // R2
  pass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (mode == 2'b00 || mode == 2'b11)) |=>
      (dn_dv && dn_data == $past(up_data) && dn_av == $past(up_av)));

  // R3
  strip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && up_av && mode == 2'b01) |=> !dn_dv);

  // R4
  strip_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !up_av && mode == 2'b01) |=>
      (dn_dv && !dn_av && dn_data == $past(up_data)));

  // R5
  replace_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !up_av && at_second && mode == 2'b10) |=>
      (dn_dv && dn_av && dn_data == $past(up_data)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_dv && dn_stall) |=>
      (dn_dv && $stable(dn_data) && $stable(dn_av)));

  // R8
  stall_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_dv && dn_stall) |-> up_stall);

endmodule

bind noc_addr_stripper noc_addr_stripper_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .up_data   (up_data),
  .up_dv     (up_dv),
  .up_av     (up_av),
  .up_stall  (up_stall),
  .dn_data   (dn_data),
  .dn_dv     (dn_dv),
  .dn_av     (dn_av),
  .dn_stall  (dn_stall),
  .at_second (at_second)
);

// File: tb/sim_noc_addr_stripper.sv
module sim_noc_addr_stripper;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic [W-1:0] up_data;
  logic         up_dv, up_av, up_stall;
  logic [W-1:0] dn_data;
  logic         dn_dv, dn_av, dn_stall;

  always #2 clk = ~clk;

  noc_addr_stripper #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .up_data(up_data), .up_dv(up_dv), .up_av(up_av), .up_stall(up_stall),
    .dn_data(dn_data), .dn_dv(dn_dv), .dn_av(dn_av), .dn_stall(dn_stall)
  );

  int errs = 0;
  int checks = 0;
  logic [W:0] expq[$];
  string      tagq[$];
  int         seen;          // flits since last address flit: 0 none seen yet
  bit         prev_hold = 0;
  logic [W:0] prev_word;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: index of the flit within its transfer decides its fate
  task automatic model(input bit av, input logic [W-1:0] d);
    int m;
    m = int'(mode);
    if (av) seen = 1;
    else if (seen > 0) seen = seen + 1;
    if (av) begin
      if (m == 0 || m == 3) begin expq.push_back({1'b1, d}); tagq.push_back("R2"); end
    end else if (seen == 2) begin
      expq.push_back({(m == 2) ? 1'b1 : 1'b0, d});
      tagq.push_back(m == 2 ? "R5" : (m == 1 ? "R4" : "R2"));
    end else begin
      expq.push_back({1'b0, d});
      tagq.push_back(m == 1 ? "R4" : (m == 2 ? "R6" : "R2"));
    end
  endtask

  task automatic step(input bit dv, input bit av, input logic [W-1:0] d, input bit st);
    logic [W:0] w;
    string t;
    @(negedge clk);
    up_dv = dv; up_av = av; up_data = d; dn_stall = st;
    #1;
    if (prev_hold)
      chk(dn_dv && {dn_av, dn_data} == prev_word, "R8", int'({dn_av, dn_data}), int'(prev_word));
    if (dn_dv && !dn_stall) begin
      if (expq.size() == 0) chk(0, "R10", int'({dn_av, dn_data}), -1);
      else begin
        w = expq.pop_front(); t = tagq.pop_front();
        chk({dn_av, dn_data} == w, t, int'({dn_av, dn_data}), int'(w));
      end
    end
    if (dn_dv && dn_stall) chk(up_stall == 1'b1, "R8", int'(up_stall), 1);
    prev_hold = dn_dv && dn_stall;
    prev_word = {dn_av, dn_data};
    if (dv && !up_stall) model(av, d);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(0, 0, '0, 0);
    chk(expq.size() == 0, "R10", expq.size(), 0);
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0; mode = 2'b00; up_data = '0; up_dv = 0; up_av = 0; dn_stall = 0;
    seen = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!dn_dv && !dn_av && !up_stall, "R1", int'({dn_dv, dn_av, up_stall}), 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!dn_dv && !dn_av, "R1", int'({dn_dv, dn_av}), 0);

    // R9: one-cycle latency in pass mode
    mode = 2'b00;
    step(1, 1, 8'h5A, 0);
    step(0, 0, '0, 0);
    chk(dn_dv && dn_av && dn_data == 8'h5A, "R9", int'({dn_dv, dn_av, dn_data}), 'h35A);
    drain();

    // R3: address flit consumed with no output cycle
    mode = 2'b01;
    step(1, 1, 8'h77, 0);
    step(0, 0, '0, 0);
    chk(!dn_dv, "R3", int'(dn_dv), 0);
    drain();

    // R7: second address flit restarts position; following flit is the address
    mode = 2'b10;
    step(1, 1, 8'h11, 0);
    step(1, 1, 8'h22, 0);
    step(1, 0, 8'h33, 0);
    step(0, 0, '0, 0);
    chk(dn_dv && dn_av && dn_data == 8'h33, "R7", int'({dn_dv, dn_av, dn_data}), 'h333);
    step(1, 0, 8'h44, 0);
    step(0, 0, '0, 0);
    chk(dn_dv && !dn_av && dn_data == 8'h44, "R6", int'({dn_dv, dn_av, dn_data}), 'h244);
    drain();

    // Sweep: every mode, three stall densities, random transfer shapes
    for (int m = 0; m < 4; m++) begin
      for (int sp = 0; sp < 3; sp++) begin
        mode = 2'(m);
        for (int c = 0; c < 400; c++) begin
          bit dv, av, st;
          dv = ($urandom % 4) != 0;
          av = (c == 0) ? 1'b1 : (($urandom % 4) == 0);
          st = (sp == 0) ? 1'b0 : ((sp == 1) ? (($urandom % 2) == 0) : (($urandom % 8) != 0));
          step(dv, av, 8'($urandom), st);
        end
        drain();
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule